// File: doc/BRIEF.md
# DMA Channel Interrupt Generator

This block produces the interrupt request and the status flag for one DMA channel. It watches the channel's transfer count, which arrives on a parallel bus, and compares it against a threshold that software can program. It also takes single-cycle pulses that report a wrap of the source or destination address around a circular buffer. Software writes a 4-bit control word that chooses the count trigger, chooses whether a count event raises a request or only sets the flag, and enables each wrap source on its own.

The count trigger has two forms. In the first, an event fires when the count changes to a value equal to the threshold. In the second, an event fires each time the count drops by exactly one. Every count event sets a sticky channel flag. It also raises a one-cycle request, but only when the control word asks for that. Software clears the flag with a write-one-to-clear strobe. The DMA datapath drives the count and wrap inputs, and the request goes on to an interrupt router.

Top module: `dma_chan_irq`

## Requirements
- R1: After a synchronous reset, the control word, the threshold, the channel flag and the request are all zero, so every interrupt source is disabled.
- R2: Control bit 0 enables the source-wrap pulse. With bit 0 set, a `src_wrap` pulse gives a request one cycle later. With bit 0 clear, the pulse gives no request.
- R3: Control bit 1 enables the destination-wrap pulse. With bit 1 set, a `dst_wrap` pulse gives a request one cycle later. With bit 1 clear, the pulse gives no request.
- R4: Control bits [3:2] form the count mode. Bit 2 picks the trigger (0 = count equals threshold, 1 = every decrement). Bit 3 picks the action (0 = flag only, 1 = flag and request). In mode 00, a count equal to the threshold sets the flag and gives no request.
- R5: In mode 01, every decrement of the count by one sets the flag and gives no request.
- R6: In mode 10, each count event at the threshold sets the flag and gives a request.
- R7: In mode 11, each decrement by one sets the flag and gives a request. A count that rises is not a decrement.
- R8: The threshold test is made only on a cycle where the count differs from its value at the previous edge. A count that stays at the threshold gives one event, not one per cycle.
- R9: The request is registered. It is high for exactly the one cycle after the edge that sampled the event.
- R10: The flag is sticky. It stays set until a cycle with `flag_clr` high and no new count event.
- R11: A count event and `flag_clr` in the same cycle leave the flag set.
- R12: Control and threshold writes take effect from the edge that stores them. An event sampled at that same edge is judged with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 4 | Control word write data |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | CNT_W | Threshold write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for the channel flag |
| tcount | input | CNT_W | Transfer count from the datapath |
| src_wrap | input | 1 | Source buffer wrap pulse |
| dst_wrap | input | 1 | Destination buffer wrap pulse |
| ctrl_rd | output | 4 | Current control word |
| thr_rd | output | CNT_W | Current threshold |
| chan_flag | output | 1 | Sticky channel status flag |
| chan_irq | output | 1 | One-cycle interrupt request |

## Verification
The bench parks the count on the threshold for several cycles. A design that compared levels instead of changes would keep setting the flag and pulsing the request. It also raises the count after a run of decrements, which a design testing "not equal" instead of "one less" would wrongly count as a decrement. A clear in the same cycle as an event catches a clear-over-set priority, because the flag would drop. Writes of the control word in the same cycle as an event catch a design that applies new settings early or late, because the request would appear one cycle off.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int CTRL_W = 4;

  // Bit positions matter: software writes the word as a plain vector.
  typedef struct packed {
    logic irq_en;   // [3] count events raise a request
    logic on_dec;   // [2] trigger on decrement instead of threshold match
    logic dst_en;   // [1] destination wrap enable
    logic src_en;   // [0] source wrap enable
  } ctrl_t;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import dma_irq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              thr_we,
  input  logic [CNT_W-1:0]  thr_wdata,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  thr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      thr_q  <= '0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
      if (thr_we)  thr_q  <= thr_wdata;
    end
  end

  AST_RESET_CLEARS_CTRL: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_q == '0 && thr_q == '0)); // R1

endmodule

// File: rtl/irq_cnt_watch.sv
module irq_cnt_watch #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tcount,
  input  logic [CNT_W-1:0] thr,
  input  logic             on_dec,
  output logic             cnt_hit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] prev_q;
  logic             prev_vld;
  logic             changed;
  logic             dec_step;
  logic             at_thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= '0;
      prev_vld <= 1'b0;
    end else begin
      prev_q   <= tcount;
      prev_vld <= 1'b1;
    end
  end

  always_comb begin
    changed  = prev_vld && (tcount != prev_q);
    dec_step = prev_vld && (tcount == prev_q - ONE);
    at_thr   = changed && (tcount == thr);
    cnt_hit  = on_dec ? dec_step : at_thr;
  end

  AST_HOLD_NO_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!on_dec && $stable(tcount) && !$past(rst)) |-> !cnt_hit); // R8

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N_WRAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_hit,
  input  logic              irq_en,
  input  logic [N_WRAP-1:0] wrap_pulse,
  input  logic [N_WRAP-1:0] wrap_en,
  input  logic              flag_clr,
  output logic              flag_q,
  output logic              irq_q
);

  logic [N_WRAP-1:0] wrap_hit;

  for (genvar g = 0; g < N_WRAP; g++) begin : g_wrap
    assign wrap_hit[g] = wrap_pulse[g] & wrap_en[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= (cnt_hit & irq_en) | (|wrap_hit);
      if (cnt_hit)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  AST_SRC_WRAP_FIRES: assert property (@(posedge clk) disable iff (rst)
    ($past(wrap_pulse[0]) && $past(wrap_en[0]) && !$past(rst)) |-> irq_q); // R2
  AST_DST_WRAP_FIRES: assert property (@(posedge clk) disable iff (rst)
    ($past(wrap_pulse[N_WRAP-1]) && $past(wrap_en[N_WRAP-1]) && !$past(rst)) |-> irq_q); // R3
  AST_SILENT_MODE: assert property (@(posedge clk) disable iff (rst)
    (!$past(irq_en) && !$past(|wrap_hit)) |-> !irq_q); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(flag_q) && !$past(flag_clr)) |-> flag_q); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_hit) && !$past(rst)) |-> flag_q); // R11

endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
  import dma_irq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              thr_we,
  input  logic [CNT_W-1:0]  thr_wdata,
  input  logic              flag_clr,
  input  logic [CNT_W-1:0]  tcount,
  input  logic              src_wrap,
  input  logic              dst_wrap,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0]  thr_rd,
  output logic              chan_flag,
  output logic              chan_irq
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] thr;
  logic             cnt_hit;

  irq_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .thr_we     (thr_we),
    .thr_wdata  (thr_wdata),
    .ctrl_q     (ctrl),
    .thr_q      (thr)
  );

  irq_cnt_watch #(.CNT_W(CNT_W)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .tcount  (tcount),
    .thr     (thr),
    .on_dec  (ctrl.on_dec),
    .cnt_hit (cnt_hit)
  );

  irq_out_stage #(.N_WRAP(2)) u_out (
    .clk        (clk),
    .rst        (rst),
    .cnt_hit    (cnt_hit),
    .irq_en     (ctrl.irq_en),
    .wrap_pulse ({dst_wrap, src_wrap}),
    .wrap_en    ({ctrl.dst_en, ctrl.src_en}),
    .flag_clr   (flag_clr),
    .flag_q     (chan_flag),
    .irq_q      (chan_irq)
  );

  assign ctrl_rd = ctrl;
  assign thr_rd  = thr;

endmodule

// File: tb/sim_dma_chan_irq.sv
module sim_dma_chan_irq;

  localparam int CNT_W = 14;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ctrl_we = 1'b0;
  logic [3:0]       ctrl_wdata = '0;
  logic             thr_we = 1'b0;
  logic [CNT_W-1:0] thr_wdata = '0;
  logic             flag_clr = 1'b0;
  logic [CNT_W-1:0] tcount = '0;
  logic             src_wrap = 1'b0;
  logic             dst_wrap = 1'b0;
  logic [3:0]       ctrl_rd;
  logic [CNT_W-1:0] thr_rd;
  logic             chan_flag;
  logic             chan_irq;

  always #4 clk = ~clk;  // 125 MHz

  dma_chan_irq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .thr_we(thr_we), .thr_wdata(thr_wdata), .flag_clr(flag_clr),
    .tcount(tcount), .src_wrap(src_wrap), .dst_wrap(dst_wrap),
    .ctrl_rd(ctrl_rd), .thr_rd(thr_rd), .chan_flag(chan_flag), .chan_irq(chan_irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  bit         q_irq[$];
  bit         q_flag[$];
  logic [3:0] q_ctrl[$];
  string      q_tag[$];

  // reference state
  logic [3:0]       m_ctrl = '0;
  logic [CNT_W-1:0] m_thr  = '0;
  logic [CNT_W-1:0] m_prev = '0;
  bit               m_vld  = 1'b0;
  bit               m_flag = 1'b0;

  task automatic step(input bit cwe, input logic [3:0] cdat, input bit twe,
                      input logic [CNT_W-1:0] tdat, input bit clr,
                      input logic [CNT_W-1:0] cnt, input bit sw, input bit dw,
                      input string tag);
    bit chg, dec, eq, hit, e_irq;
    @(negedge clk);
    ctrl_we = cwe; ctrl_wdata = cdat; thr_we = twe; thr_wdata = tdat;
    flag_clr = clr; tcount = cnt; src_wrap = sw; dst_wrap = dw;
    chg = m_vld && (cnt != m_prev);
    dec = m_vld && (cnt == m_prev - 1);
    eq  = chg && (cnt == m_thr);
    hit = m_ctrl[2] ? dec : eq;
    e_irq = (hit && m_ctrl[3]) || (sw && m_ctrl[0]) || (dw && m_ctrl[1]);
    if (hit) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    if (cwe) m_ctrl = cdat;
    if (twe) m_thr = tdat;
    m_prev = cnt;
    m_vld = 1'b1;
    q_irq.push_back(e_irq);
    q_flag.push_back(m_flag);
    q_ctrl.push_back(m_ctrl);
    q_tag.push_back(tag);
  endtask

  // plain cycle: count and optional clear only
  task automatic cyc(input logic [CNT_W-1:0] cnt, input bit clr, input string tag);
    step(1'b0, 4'h0, 1'b0, '0, clr, cnt, 1'b0, 1'b0, tag);
  endtask

  task automatic wr_ctrl(input logic [3:0] v, input logic [CNT_W-1:0] cnt, input string tag);
    step(1'b1, v, 1'b0, '0, 1'b0, cnt, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare away from the clock edge
  always @(posedge clk) begin
    #2;
    if (q_irq.size() > 0) begin
      bit e_i, e_f;
      logic [3:0] e_c;
      string t;
      e_i = q_irq.pop_front(); e_f = q_flag.pop_front();
      e_c = q_ctrl.pop_front(); t = q_tag.pop_front();
      n_cmp++;
      if (chan_irq !== e_i || chan_flag !== e_f || ctrl_rd !== e_c) begin
        n_bad++;
        $display("FAIL %s: irq/flag/ctrl actual %b/%b/%h expected %b/%b/%h",
                 t, chan_irq, chan_flag, ctrl_rd, e_i, e_f, e_c);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    n_cmp++;
    if (ctrl_rd !== 4'h0 || thr_rd !== '0 || chan_flag !== 1'b0 || chan_irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: ctrl/thr/flag/irq actual %h/%0d/%b/%b expected 0/0/0/0",
               ctrl_rd, thr_rd, chan_flag, chan_irq);
    end

    // wraps while disabled (R2, R3 ignored)
    cyc(20, 0, "R1");
    step(0, 4'h0, 0, '0, 0, 20, 1, 0, "R2 disabled");
    step(0, 4'h0, 0, '0, 0, 20, 0, 1, "R3 disabled");
    cyc(20, 0, "R2");
    // enable source wrap only
    wr_ctrl(4'h1, 20, "R2 write");
    step(0, 4'h0, 0, '0, 0, 20, 1, 0, "R2 enabled");
    step(0, 4'h0, 0, '0, 0, 20, 0, 1, "R3 off while R2 on");
    cyc(20, 0, "R9 pulse ends");
    wr_ctrl(4'h2, 20, "R3 write");
    step(0, 4'h0, 0, '0, 0, 20, 1, 0, "R2 off while R3 on");
    step(0, 4'h0, 0, '0, 0, 20, 0, 1, "R3 enabled");
    step(0, 4'h0, 0, '0, 0, 20, 1, 1, "R3 both wraps");

    // mode 00 threshold 15, flag only
    step(1, 4'h0, 1, 15, 0, 20, 0, 0, "R4 setup");
    for (int c = 19; c >= 15; c--) cyc(c[CNT_W-1:0], 0, "R4 mode00");
    for (int k = 0; k < 3; k++) cyc(15, 0, "R8 hold");
    cyc(14, 1, "R10 clear");
    cyc(14, 0, "R10 cleared");
    cyc(15, 0, "R8 re-enter");
    cyc(15, 1, "R10 clear2");

    // mode 01 every decrement, flag only
    wr_ctrl(4'h4, 15, "R5 write");
    cyc(14, 0, "R5 dec");
    cyc(14, 1, "R5 clear");
    cyc(14, 0, "R5 hold");
    cyc(16, 0, "R5 rise");
    cyc(13, 0, "R5 jump");
    cyc(12, 1, "R11 set vs clear");
    cyc(12, 1, "R10 clear");

    // mode 10 threshold 8 with request
    step(1, 4'h8, 1, 8, 0, 12, 0, 0, "R6 setup");
    for (int c = 11; c >= 7; c--) cyc(c[CNT_W-1:0], 0, "R6 mode10");
    cyc(8, 0, "R6 up to thr");
    cyc(8, 0, "R8 hold");
    cyc(8, 1, "R10 clear");
    cyc(9, 0, "R9 idle");

    // mode 11 every decrement with request
    wr_ctrl(4'hC, 9, "R7 write");
    for (int c = 8; c >= 4; c--) cyc(c[CNT_W-1:0], 0, "R7 mode11");
    cyc(30, 0, "R7 reload");
    cyc(30, 1, "R10 clear");
    cyc(29, 1, "R11 collide");
    cyc(29, 0, "R9 single pulse");

    // R12: write changes mode in same cycle as an event
    wr_ctrl(4'h0, 28, "R12 old mode11 applies");
    cyc(27, 1, "R12 new mode00 no dec event");
    step(1, 4'hC, 1, 26, 0, 26, 0, 0, "R12 old thr and mode");
    cyc(25, 0, "R12 new mode live");
    step(0, 4'h0, 1, 24, 0, 24, 0, 0, "R12 thr write");

    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule